// File: doc/BRIEF.md
# Asynchronous PSRAM Access Controller

This block sits between a synchronous host and a 16-bit asynchronous pseudo-static RAM. The memory has two chip enables of opposite polarity (an active-low enable and an active-high enable), an active-low write strobe, an active-low output enable and two active-low byte-lane enables. The host issues single read or write requests carrying an address, a 16-bit data word and a 2-bit byte mask. The controller converts each request into a strobe sequence whose phase lengths are parameterised cycle counts. It returns read data with a one-cycle `done` pulse.

After reset the controller keeps both chip enables inactive for a power-up wait of `INIT_CYC` cycles. Only then does it raise `ready`. When no access is in progress it parks the memory in standby, where the array keeps its contents and refreshes itself. On request it enters deep power-down by pulling the active-high enable low. Leaving deep power-down repeats the whole power-up wait. The data bus is split into an output word, an output-enable and an input word, so the tristate buffer can sit at the pad.

States:
- `ST_INIT` is the power-up wait.
- `ST_IDLE` is standby and is ready for a request.
- `ST_RD_WAIT` covers the read access delay.
- `ST_RD_END` finishes a read.
- `ST_WR_TURN` covers the memory's output release.
- `ST_WR_DRIVE` is the data setup phase.
- `ST_WR_HOLD` holds the data after the write strobe rises.
- `ST_WR_END` finishes a write.
- `ST_DPD` is deep power-down.

Transitions:
- INIT→IDLE when the wait expires.
- IDLE→RD_WAIT or IDLE→WR_TURN when a request is accepted.
- IDLE→DPD on a power-down request.
- RD_WAIT→RD_END, then RD_END→IDLE.
- WR_TURN→WR_DRIVE→WR_HOLD→WR_END, each when its count expires, then WR_END→IDLE.
- DPD→INIT on a wake request.

Top module: `psram_ctrl`

## Requirements
- R1: After reset `ready` is low and the active-low enable `mem_e1_n` and the active-high enable `mem_e2` are both high. `ready` rises right after the `INIT_CYC`-th rising clock edge following reset release.
- R2: A read drives `mem_e1_n`=0, `mem_e2`=1, `mem_we_n`=1 and `mem_oe_n`=0. Mask bit 0 (low byte, DQ7..DQ0) drives `mem_lb_n`=0 and mask bit 1 (high byte, DQ15..DQ8) drives `mem_ub_n`=0, both active low. These strobes last exactly `RD_CYC` cycles.
- R3: Read data is sampled on the edge that ends the `RD_CYC` window. `rd_data` holds the sampled word with every byte whose mask bit is 0 forced to zero. `done` is high for exactly one cycle, with `mem_e1_n` high.
- R4: A write first holds `mem_we_n`=0 and `mem_e1_n`=0 with the data bus undriven (`mem_dq_oe`=0) for exactly `TURN_CYC` cycles.
- R5: The write data is then driven for exactly `SETUP_CYC` cycles while `mem_we_n` is still low.
- R6: `mem_we_n` rises before `mem_e1_n`. The data stays driven for exactly `HOLD_CYC` cycles after `mem_we_n` rises. Then `mem_e1_n` rises, the bus is released and `done` pulses.
- R7: A write changes only the byte lanes selected by the mask, with the lane mapping of R2.
- R8: A request with a zero mask is ignored. No strobe moves, `done` stays low and `ready` stays high.
- R9: `ready` is low while an access is in progress. A request is accepted only on an edge where `ready` is high.
- R10: In standby both enables are high, and stored words read back unchanged after idle time.
- R11: In deep power-down `mem_e2`=0 and `mem_e1_n`=1, `ready` is low and access requests are ignored. A wake request restarts the full `INIT_CYC` wait.
- R12: `mem_dq_oe` is never high while `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask, bit 0 low byte, bit 1 high byte |
| dpd_req | input | 1 | Enter deep power-down (from standby) |
| wake_req | input | 1 | Leave deep power-down |
| ready | output | 1 | Controller accepts a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Masked read data |
| mem_addr | output | AW | Memory address |
| mem_e1_n | output | 1 | Active-low chip enable |
| mem_e2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Write strobe |
| mem_oe_n | output | 1 | Output enable |
| mem_lb_n | output | 1 | Low byte enable |
| mem_ub_n | output | 1 | High byte enable |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
A state or counter error shows up at the memory pins within the same access. A phase that is one cycle short or long changes the measured turnaround, setup, hold or read-window length, and those lengths are checked when the active-low enable rises. A read window that is too short samples the model's "not yet valid" pattern, so the returned word is wrong at the next `done`. A wrong lane mapping corrupts the scoreboard on the next read-back. A broken wait counter moves the `ready` rise away from its computed cycle after reset or after wake.

// File: rtl/psc_pkg.sv
package psc_pkg;
    typedef enum logic [3:0] {
        ST_INIT, ST_IDLE, ST_RD_WAIT, ST_RD_END,
        ST_WR_TURN, ST_WR_DRIVE, ST_WR_HOLD, ST_WR_END, ST_DPD
    } psc_state_e;

    function automatic int psc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/psc_timer.sv
module psc_timer #(
    parameter int CW      = 8,
    parameter int RST_VAL = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= CW'(RST_VAL);
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/psc_lane.sv
module psc_lane #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    input  logic [1:0]    req_mask,
    input  logic [15:0]   dq_in,
    output logic [AW-1:0] addr_q,
    output logic [1:0]    mask_q,
    output logic [15:0]   wdata_q,
    output logic [15:0]   rdata_q
);
    logic [15:0] lane_bits;

    assign lane_bits = {{8{mask_q[1]}}, {8{mask_q[0]}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            mask_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                mask_q  <= req_mask;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= dq_in & lane_bits;
        end
    end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psc_pkg::*;
#(
    parameter int AW        = 20,
    parameter int INIT_CYC  = 15000,
    parameter int RD_CYC    = 4,
    parameter int TURN_CYC  = 2,
    parameter int SETUP_CYC = 3,
    parameter int HOLD_CYC  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    input  logic [1:0]    req_mask,
    input  logic          dpd_req,
    input  logic          wake_req,
    output logic          ready,
    output logic          done,
    output logic [15:0]   rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_e1_n,
    output logic          mem_e2,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_lb_n,
    output logic          mem_ub_n,
    output logic [15:0]   mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [15:0]   mem_dq_i
);
    localparam int MAXC = psc_max(psc_max(INIT_CYC, RD_CYC),
                                  psc_max(TURN_CYC, psc_max(SETUP_CYC, HOLD_CYC)));
    localparam int CW   = $clog2(MAXC + 1);

    psc_state_e    state, state_nx;
    logic          tmr_load, tmr_done, accept, capture, active;
    logic [CW-1:0] tmr_val;
    logic [1:0]    mask_q;

    psc_timer #(.CW(CW), .RST_VAL(INIT_CYC - 1)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
    );

    psc_lane #(.AW(AW)) u_lane (
        .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .dq_in(mem_dq_i), .addr_q(mem_addr), .mask_q(mask_q),
        .wdata_q(mem_dq_o), .rdata_q(rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_INIT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        unique case (state)
            ST_INIT: if (tmr_done) state_nx = ST_IDLE;
            ST_IDLE: begin
                if (dpd_req) begin
                    state_nx = ST_DPD;
                end else if (req_valid && req_mask != 2'b00) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_nx = ST_WR_TURN;
                        tmr_val  = CW'(TURN_CYC - 1);
                    end else begin
                        state_nx = ST_RD_WAIT;
                        tmr_val  = CW'(RD_CYC - 1);
                    end
                end
            end
            ST_RD_WAIT: if (tmr_done) begin
                state_nx = ST_RD_END;
                capture  = 1'b1;
            end
            ST_RD_END: state_nx = ST_IDLE;
            ST_WR_TURN: if (tmr_done) begin
                state_nx = ST_WR_DRIVE;
                tmr_load = 1'b1;
                tmr_val  = CW'(SETUP_CYC - 1);
            end
            ST_WR_DRIVE: if (tmr_done) begin
                state_nx = ST_WR_HOLD;
                tmr_load = 1'b1;
                tmr_val  = CW'(HOLD_CYC - 1);
            end
            ST_WR_HOLD: if (tmr_done) state_nx = ST_WR_END;
            ST_WR_END:  state_nx = ST_IDLE;
            ST_DPD: if (wake_req) begin
                state_nx = ST_INIT;
                tmr_load = 1'b1;
                tmr_val  = CW'(INIT_CYC - 1);
            end
            default: state_nx = ST_INIT;
        endcase
    end

    always_comb begin
        ready     = 1'b0;
        done      = 1'b0;
        active    = 1'b0;
        mem_e2    = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state)
            ST_INIT:     ;
            ST_IDLE:     ready = 1'b1;
            ST_RD_WAIT:  begin active = 1'b1; mem_oe_n = 1'b0; end
            ST_RD_END:   done = 1'b1;
            ST_WR_TURN:  begin active = 1'b1; mem_we_n = 1'b0; end
            ST_WR_DRIVE: begin active = 1'b1; mem_we_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_WR_HOLD:  begin active = 1'b1; mem_dq_oe = 1'b1; end
            ST_WR_END:   done = 1'b1;
            ST_DPD:      mem_e2 = 1'b0;
            default:     ;
        endcase
        mem_e1_n = !active;
        mem_lb_n = !(active && mask_q[0]);
        mem_ub_n = !(active && mask_q[1]);
    end

    // R12: never drive the bus while the memory may be driving it
    a_r12_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
    // R4: data bus stays released on the cycle the write strobe falls
    a_r4_turn_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe);
    // R6: write strobe rises before the chip enable
    a_r6_we_before_e1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_e1_n) |-> $past(mem_we_n));
    // R6: data still driven when the write strobe rises
    a_r6_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && !mem_e1_n) |-> mem_dq_oe);
    // R9: no completion while ready
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ready);
    // R11: deep power-down keeps E1 inactive and blocks requests
    a_r11_dpd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_e2 |-> (mem_e1_n && !ready));
    // R8: zero-mask request is ignored
    a_r8_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && req_mask == 2'b00 && !dpd_req) |=> (ready && mem_e1_n));
endmodule

// File: tb/psram_ctrl_test.sv
`timescale 1ns/1ps
module psram_ctrl_test;
    localparam int AW = 4, INIT = 20, RDC = 3, TURN = 2, SETUP = 2, HOLD = 2;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, dpd_req = 0, wake_req = 0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0] req_mask = '0;
    logic ready, done, mem_e1_n, mem_e2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] rd_data, mem_dq_o, mem_dq_i;
    logic [AW-1:0] mem_addr;

    int checks = 0, fails = 0;
    bit finished = 0;

    psram_ctrl #(.AW(AW), .INIT_CYC(INIT), .RD_CYC(RDC), .TURN_CYC(TURN),
                 .SETUP_CYC(SETUP), .HOLD_CYC(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .dpd_req(dpd_req), .wake_req(wake_req), .ready(ready), .done(done),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_e1_n(mem_e1_n), .mem_e2(mem_e2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model
    logic [15:0] mem [16];
    logic [15:0] expm [16];
    int rcnt = 0, turn_c = 0, setup_c = 0, hold_c = 0, rd_c = 0, contention = 0;
    bit saw_w = 0, prev_e1 = 1, prev_we = 1;

    assign mem_dq_i = (!mem_e1_n && mem_e2 && !mem_oe_n && mem_we_n && rcnt >= RDC)
                      ? mem[mem_addr] : 16'hBAD0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && !mem_oe_n) contention++;
            if (!prev_we && mem_we_n && !mem_e1_n && mem_e2) begin
                if (!mem_lb_n) mem[mem_addr][7:0]  = mem_dq_o[7:0];
                if (!mem_ub_n) mem[mem_addr][15:8] = mem_dq_o[15:8];
            end
            if (!mem_e1_n) begin
                if (!mem_we_n && !mem_dq_oe) turn_c++;
                if (!mem_we_n && mem_dq_oe)  setup_c++;
                if (mem_we_n && mem_dq_oe)   hold_c++;
                if (!mem_oe_n) rd_c++;
                if (!mem_we_n) saw_w = 1;
            end else if (!prev_e1) begin
                if (saw_w) begin
                    check(turn_c == TURN, "R4 turnaround cycles", turn_c, TURN);
                    check(setup_c == SETUP, "R5 setup cycles", setup_c, SETUP);
                    check(hold_c == HOLD, "R6 hold cycles", hold_c, HOLD);
                end else begin
                    check(rd_c == RDC, "R2 read strobe cycles", rd_c, RDC);
                end
                turn_c = 0; setup_c = 0; hold_c = 0; rd_c = 0; saw_w = 0;
            end
            if (!mem_e1_n && mem_e2 && !mem_oe_n && mem_we_n) rcnt++;
            else rcnt = 0;
        end
        prev_e1 = mem_e1_n;
        prev_we = mem_we_n;
    end

    task automatic access(input bit wr, input int a, input logic [15:0] d,
                          input logic [1:0] m, output logic [15:0] q);
        int guard = 0;
        while (!ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 0;
        check(!ready, "R9 ready low when busy", ready, 0);
        check({mem_e1_n, mem_e2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n} ==
              {1'b0, 1'b1, !wr, wr, !m[1], !m[0]}, wr ? "R7 write strobes" : "R2 read strobes",
              {mem_e1_n, mem_e2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n},
              {1'b0, 1'b1, !wr, wr, !m[1], !m[0]});
        while (!done && guard < 100) begin @(negedge clk); guard++; end
        check(done && mem_e1_n, "R3 done with E1 high", {done, mem_e1_n}, 2'b11);
        q = rd_data;
        @(negedge clk);
        check(!done, "R3 done one cycle", done, 0);
    endtask

    task automatic rd_check(input int a, input logic [1:0] m, input string tag);
        logic [15:0] q, e;
        e = expm[a] & {{8{m[1]}}, {8{m[0]}}};
        access(0, a, 16'h0, m, q);
        check(q == e, tag, q, e);
    endtask

    task automatic wr(input int a, input logic [15:0] d, input logic [1:0] m);
        logic [15:0] q;
        access(1, a, d, m, q);
        if (m[0]) expm[a][7:0]  = d[7:0];
        if (m[1]) expm[a][15:8] = d[15:8];
    endtask

    initial begin
        int n;
        bit init_ok;
        for (int i = 0; i < 16; i++) begin mem[i] = 16'h0; expm[i] = 16'h0; end
        repeat (3) @(negedge clk);
        check(!ready && mem_e1_n && mem_e2, "R1 reset state", {ready, mem_e1_n, mem_e2}, 3'b011);
        rst_n = 1;
        n = 0; init_ok = 1;
        while (!ready && n < 1000) begin
            @(posedge clk); n++; #1;
            if (!(mem_e1_n && mem_e2)) init_ok = 0;
        end
        check(n == INIT, "R1 init wait length", n, INIT);
        check(init_ok, "R1 enables high during init", init_ok, 1);
        @(negedge clk);

        for (int a = 0; a < 16; a++) wr(a, 16'(a * 16'h1357 + 16'h0F0F), 2'b11);
        for (int a = 0; a < 16; a++) rd_check(a, 2'b11, "R3 full read");
        for (int a = 0; a < 16; a++) begin
            wr(a, 16'(16'hA5C3 ^ (a * 16'h0101)), 2'(a % 3 + 1));
        end
        for (int a = 0; a < 16; a++) rd_check(a, 2'b11, "R7 lane write");
        for (int a = 0; a < 4; a++) begin
            rd_check(a, 2'b01, "R3 low byte mask");
            rd_check(a, 2'b10, "R3 high byte mask");
        end

        // zero mask
        req_valid = 1; req_write = 1; req_addr = 4'd5; req_wdata = 16'hFFFF; req_mask = 2'b00;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(ready && mem_e1_n && !done, "R8 zero mask ignored", {ready, mem_e1_n, done}, 3'b110);
        end
        req_valid = 0;
        rd_check(5, 2'b11, "R8 data unchanged");

        // standby retention
        repeat (40) begin
            @(negedge clk);
        end
        check(mem_e1_n && mem_e2, "R10 standby enables", {mem_e1_n, mem_e2}, 2'b11);
        rd_check(9, 2'b11, "R10 retention");

        // deep power-down
        dpd_req = 1; @(negedge clk); dpd_req = 0;
        check(!mem_e2 && mem_e1_n && !ready, "R11 dpd pins", {mem_e2, mem_e1_n, ready}, 3'b010);
        req_valid = 1; req_write = 0; req_mask = 2'b11;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(mem_e1_n && !mem_e2 && !done, "R11 request ignored", {mem_e1_n, mem_e2, done}, 3'b100);
        end
        req_valid = 0;
        wake_req = 1;
        n = 0;
        @(posedge clk); n++; #1; wake_req = 0;
        while (!ready && n < 1000) begin @(posedge clk); n++; #1; end
        check(n == INIT + 1, "R11 wake repeats init", n, INIT + 1);
        @(negedge clk);
        rd_check(2, 2'b11, "R11 access after wake");

        check(contention == 0, "R12 no bus contention", contention, 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule